// File: doc/BRIEF.md
# Shared Register Bus Datapath

This block is the register file and interconnect of a small accumulator machine. Six working registers and a word-wide memory can each be the single driver of a 16-bit shared bus. A 3-bit source code selects the driver. Every register takes its next value from that bus. Two registers are 12 bits wide: the address register and the program counter. Four are 16 bits wide: the data register, the accumulator, the instruction register and a temporary register. An 8-bit output register only listens to the bus.

An 8-bit input register captures a byte from outside. The accumulator can take that byte directly, zero-extended. Each register has its own load, increment and clear strobes, and it holds its value whenever none of them is asserted. The memory is addressed only by the address register. It returns its word on the bus in the same cycle it is selected, and it writes the bus value at a clock edge.

The sequencing logic, the arithmetic unit and the character devices sit outside this block. They drive the strobes and the source code every cycle and watch the exposed register contents.

Top module: `acc_bus_datapath`

## Requirements
- R1: The bus shows all zeros for source code 000. It shows the address register for 001, the program counter for 010, the data register for 011, the accumulator for 100, the instruction register for 101 and the temporary register for 110. Code 111 shows the memory word only while the memory read strobe is high, and zeros otherwise. The 12-bit registers appear on the bus zero-extended to 16 bits.
- R2: A register whose load strobe is high captures the bus at the next rising clock edge. The 12-bit registers keep bus bits 11:0 and the output register keeps bus bits 7:0.
- R3: A register whose increment strobe is high, with no load or clear, becomes its old value plus one at the next rising edge.
- R4: When several strobes of one register are high together, clear wins over load, and load wins over increment.
- R5: A register with none of its strobes high keeps its value across the clock edge.
- R6: With the memory write strobe high, the word addressed by the current address register takes the bus value at the rising edge. A later read of that word through source code 111 returns it in the same cycle it is selected. The address register can be incremented in the same cycle as the write, and the write still goes to the old address.
- R7: The output register is a sink. No source code places it on the bus, and loading it leaves every bus-driving register unchanged.
- R8: The input register captures the external byte when its load strobe is high. The accumulator's input-transfer strobe loads the accumulator with that byte zero-extended. If the accumulator's bus load strobe is also high in that cycle, the bus value wins.
- R9: Driving the reset input low clears every register at once without waiting for a clock. After release, registers stay cleared for two rising edges and then respond to their strobes.

Strobe vectors `ld_i`, `inr_i` and `clr_i` use bit 0 for the address register, bit 1 for the program counter, bit 2 for the data register, bit 3 for the accumulator, bit 4 for the instruction register, bit 5 for the temporary register and bit 6 for the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 3 | Bus source code |
| mem_rd_i | input | 1 | Memory read strobe, drives the bus when the code is 111 |
| mem_wr_i | input | 1 | Memory write strobe |
| ld_i | input | 7 | Per-register load strobes |
| inr_i | input | 7 | Per-register increment strobes |
| clr_i | input | 7 | Per-register clear strobes |
| in_byte_i | input | 8 | Byte from the input side |
| inp_ld_i | input | 1 | Input register load strobe |
| ac_ld_inp_i | input | 1 | Accumulator load from input register |
| bus_o | output | 16 | Current bus value |
| ar_o | output | 12 | Address register |
| pc_o | output | 12 | Program counter |
| dr_o | output | 16 | Data register |
| ac_o | output | 16 | Accumulator |
| ir_o | output | 16 | Instruction register |
| tr_o | output | 16 | Temporary register |
| outr_o | output | 8 | Output register |
| inpr_o | output | 8 | Input register |

## Verification
Two pairs of functions can fall in the same cycle. The first is a memory write together with an increment of the address register that feeds the memory address. The bench writes with the increment strobe high, reloads the old address and reads it back, and it passes only if the data landed at the old address. The second is that several strobes on one register collide. The bench raises clear with increment, clear with load, load with increment, and the bus load with the input transfer on the accumulator, and it judges each case by the register value one edge later against the priority order of R4 and R8.

// File: rtl/abus_pkg.sv
package abus_pkg;
  localparam int DW    = 16;  // bus and wide register width
  localparam int AW    = 12;  // address and program counter width
  localparam int CW    = 8;   // character register width
  localparam int NREG  = 7;   // registers with strobes
  localparam int NSRC  = 6;   // registers able to drive the bus

  localparam int IDX_AR  = 0;
  localparam int IDX_PC  = 1;
  localparam int IDX_DR  = 2;
  localparam int IDX_AC  = 3;
  localparam int IDX_IR  = 4;
  localparam int IDX_TR  = 5;
  localparam int IDX_OUT = 6;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } bus_src_e;

  function automatic int reg_width(input int idx);
    if (idx == IDX_AR || idx == IDX_PC) return AW;
    if (idx == IDX_OUT)                 return CW;
    return DW;
  endfunction
endpackage

// File: rtl/abus_reg.sv
module abus_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  input  logic         ld_i,
  input  logic         inr_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_nxt;
  logic         en;

  // clear, then load, then increment
  always_comb begin
    en = clr_i | ld_i | inr_i;
    if (clr_i)      q_nxt = '0;
    else if (ld_i)  q_nxt = d_i;
    else if (inr_i) q_nxt = q_o + W'(1);
    else            q_nxt = q_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_o <= '0;
    else if (en) q_o <= q_nxt;
  end
endmodule

// File: rtl/abus_mem.sv
module abus_mem #(
  parameter int DEPTH = 1024,
  parameter int DW    = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [IW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) store[addr_i] <= wdata_i;
  end

  assign rdata_o = store[addr_i];
endmodule

// File: rtl/abus_mux.sv
module abus_mux
  import abus_pkg::*;
(
  input  logic [2:0]    sel_i,
  input  logic          mem_rd_i,
  input  logic [DW-1:0] src_i [NSRC],
  input  logic [DW-1:0] mem_i,
  output logic [DW-1:0] bus_o
);
  bus_src_e sel;

  always_comb begin
    sel = bus_src_e'(sel_i);
    unique case (sel)
      SRC_AR:  bus_o = src_i[IDX_AR];
      SRC_PC:  bus_o = src_i[IDX_PC];
      SRC_DR:  bus_o = src_i[IDX_DR];
      SRC_AC:  bus_o = src_i[IDX_AC];
      SRC_IR:  bus_o = src_i[IDX_IR];
      SRC_TR:  bus_o = src_i[IDX_TR];
      SRC_MEM: bus_o = mem_rd_i ? mem_i : '0;
      default: bus_o = '0;
    endcase
  end
endmodule

// File: rtl/acc_bus_datapath.sv
module acc_bus_datapath
  import abus_pkg::*;
#(
  parameter int MEM_WORDS = 1024,
  localparam int MIW      = $clog2(MEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      bus_sel_i,
  input  logic            mem_rd_i,
  input  logic            mem_wr_i,
  input  logic [NREG-1:0] ld_i,
  input  logic [NREG-1:0] inr_i,
  input  logic [NREG-1:0] clr_i,
  input  logic [CW-1:0]   in_byte_i,
  input  logic            inp_ld_i,
  input  logic            ac_ld_inp_i,
  output logic [DW-1:0]   bus_o,
  output logic [AW-1:0]   ar_o,
  output logic [AW-1:0]   pc_o,
  output logic [DW-1:0]   dr_o,
  output logic [DW-1:0]   ac_o,
  output logic [DW-1:0]   ir_o,
  output logic [DW-1:0]   tr_o,
  output logic [CW-1:0]   outr_o,
  output logic [CW-1:0]   inpr_o
);
  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic [DW-1:0] bus;
  logic [DW-1:0] reg_q [NSRC];
  logic [DW-1:0] mem_rdata;
  logic [CW-1:0] inpr_q;
  logic [CW-1:0] outr_q;

  // reset asserts at once, releases after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // bus-driving registers
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam int W = reg_width(g);
    logic [W-1:0] q_w;
    logic [W-1:0] d_w;
    logic         ld_w;

    if (g == IDX_AC) begin : g_acc
      // bus load takes precedence over the byte transfer
      assign d_w  = ld_i[g] ? bus[W-1:0] : W'(inpr_q);
      assign ld_w = ld_i[g] | ac_ld_inp_i;
    end else begin : g_plain
      assign d_w  = bus[W-1:0];
      assign ld_w = ld_i[g];
    end

    abus_reg #(.W(W)) u_reg (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .d_i  (d_w),
      .ld_i (ld_w),
      .inr_i(inr_i[g]),
      .clr_i(clr_i[g]),
      .q_o  (q_w)
    );
    assign reg_q[g] = DW'(q_w);
  end

  // sink-only output register
  abus_reg #(.W(CW)) u_outr (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d_i  (bus[CW-1:0]),
    .ld_i (ld_i[IDX_OUT]),
    .inr_i(inr_i[IDX_OUT]),
    .clr_i(clr_i[IDX_OUT]),
    .q_o  (outr_q)
  );

  // input character register
  abus_reg #(.W(CW)) u_inpr (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d_i  (in_byte_i),
    .ld_i (inp_ld_i),
    .inr_i(1'b0),
    .clr_i(1'b0),
    .q_o  (inpr_q)
  );

  abus_mem #(.DEPTH(MEM_WORDS), .DW(DW)) u_mem (
    .clk    (clk),
    .addr_i (reg_q[IDX_AR][MIW-1:0]),
    .we_i   (mem_wr_i),
    .wdata_i(bus),
    .rdata_o(mem_rdata)
  );

  abus_mux u_mux (
    .sel_i   (bus_sel_i),
    .mem_rd_i(mem_rd_i),
    .src_i   (reg_q),
    .mem_i   (mem_rdata),
    .bus_o   (bus)
  );

  assign bus_o  = bus;
  assign ar_o   = reg_q[IDX_AR][AW-1:0];
  assign pc_o   = reg_q[IDX_PC][AW-1:0];
  assign dr_o   = reg_q[IDX_DR];
  assign ac_o   = reg_q[IDX_AC];
  assign ir_o   = reg_q[IDX_IR];
  assign tr_o   = reg_q[IDX_TR];
  assign outr_o = outr_q;
  assign inpr_o = inpr_q;
endmodule

// File: rtl/abus_chk.sv
module abus_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  sel,
  input logic [15:0] bus,
  input logic        ld_ar,
  input logic        inr_ar,
  input logic        clr_ar,
  input logic        ld_pc,
  input logic        clr_pc,
  input logic        ld_dr,
  input logic        inr_dr,
  input logic        clr_dr,
  input logic        clr_ac,
  input logic        ld_out,
  input logic        clr_out,
  input logic [11:0] ar,
  input logic [11:0] pc,
  input logic [15:0] dr,
  input logic [15:0] ac,
  input logic [7:0]  outr
);
  // R1
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 3'd0 |-> bus == 16'h0000);

  // R1
  narrow_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 3'd1 |-> bus[15:12] == 4'h0);

  // R2
  pc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pc && !clr_pc |=> pc == $past(bus[11:0]));

  // R3
  ar_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inr_ar && !ld_ar && !clr_ar |=> ar == $past(ar) + 12'd1);

  // R4
  clear_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ac |=> ac == 16'h0000);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_dr && !inr_dr && !clr_dr |=> $stable(dr));

  // R7
  sink_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_out && !clr_out |=> outr == $past(bus[7:0]));
endmodule

bind acc_bus_datapath abus_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .sel    (bus_sel_i),
  .bus    (bus_o),
  .ld_ar  (ld_i[0]),
  .inr_ar (inr_i[0]),
  .clr_ar (clr_i[0]),
  .ld_pc  (ld_i[1]),
  .clr_pc (clr_i[1]),
  .ld_dr  (ld_i[2]),
  .inr_dr (inr_i[2]),
  .clr_dr (clr_i[2]),
  .clr_ac (clr_i[3]),
  .ld_out (ld_i[6]),
  .clr_out(clr_i[6]),
  .ar     (ar_o),
  .pc     (pc_o),
  .dr     (dr_o),
  .ac     (ac_o),
  .outr   (outr_o)
);

// File: tb/acc_bus_datapath_tb.sv
module acc_bus_datapath_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_sel = '0;
  logic        mem_rd = 1'b0;
  logic        mem_wr = 1'b0;
  logic [6:0]  ld = '0;
  logic [6:0]  inr = '0;
  logic [6:0]  clr = '0;
  logic [7:0]  in_byte = '0;
  logic        inp_ld = 1'b0;
  logic        ac_ld_inp = 1'b0;
  logic [15:0] bus_w, dr_w, ac_w, ir_w, tr_w;
  logic [11:0] ar_w, pc_w;
  logic [7:0]  outr_w, inpr_w;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  acc_bus_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel), .mem_rd_i(mem_rd),
    .mem_wr_i(mem_wr), .ld_i(ld), .inr_i(inr), .clr_i(clr),
    .in_byte_i(in_byte), .inp_ld_i(inp_ld), .ac_ld_inp_i(ac_ld_inp),
    .bus_o(bus_w), .ar_o(ar_w), .pc_o(pc_w), .dr_o(dr_w), .ac_o(ac_w),
    .ir_o(ir_w), .tr_o(tr_w), .outr_o(outr_w), .inpr_o(inpr_w)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [6:0]  ld;
    logic [6:0]  inr;
    logic [6:0]  clr;
    logic        inp_ld;
    logic        ac_inp;
    logic        rd;
    logic        wr;
    logic [7:0]  din;
    logic [15:0] exp_bus;
    logic [2:0]  chk;   // 0..6 strobe index, 7 input register
    logic [15:0] exp_val;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 7'h00, 7'h00, 7'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, 16'h0000, 3'd7, 16'h005A}, // R8
    '{3'd0, 7'h00, 7'h00, 7'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 3'd3, 16'h005A}, // R8
    '{3'd4, 7'h04, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h005A, 3'd2, 16'h005A}, // R1 R2
    '{3'd3, 7'h02, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h005A, 3'd1, 16'h005A}, // R2
    '{3'd2, 7'h00, 7'h02, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h005A, 3'd1, 16'h005B}, // R3
    '{3'd2, 7'h01, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h005B, 3'd0, 16'h005B}, // R2
    '{3'd4, 7'h00, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 16'h005A, 3'd0, 16'h005B}, // R6
    '{3'd7, 7'h20, 7'h00, 7'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 16'h005A, 3'd5, 16'h005A}, // R6
    '{3'd7, 7'h10, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, 3'd4, 16'h0000}, // R1
    '{3'd5, 7'h00, 7'h20, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, 3'd5, 16'h005B}, // R3
    '{3'd6, 7'h40, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h005B, 3'd6, 16'h005B}, // R7
    '{3'd4, 7'h00, 7'h08, 7'h08, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h005A, 3'd3, 16'h0000}, // R4
    '{3'd1, 7'h04, 7'h00, 7'h04, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h005B, 3'd2, 16'h0000}, // R4
    '{3'd1, 7'h08, 7'h08, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h005B, 3'd3, 16'h005B}, // R4
    '{3'd4, 7'h00, 7'h01, 7'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 16'h005B, 3'd0, 16'h005C}, // R6
    '{3'd4, 7'h01, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h005B, 3'd0, 16'h005B}, // R2
    '{3'd7, 7'h04, 7'h00, 7'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 16'h005B, 3'd2, 16'h005B}, // R6
    '{3'd0, 7'h00, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, 3'd1, 16'h005B}, // R5
    '{3'd0, 7'h00, 7'h00, 7'h08, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, 3'd3, 16'h0000}, // R4
    '{3'd6, 7'h08, 7'h00, 7'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h005B, 3'd3, 16'h005B}, // R8
    '{3'd2, 7'h00, 7'h00, 7'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 16'h005B, 3'd7, 16'h005A}  // R1 R8
  };

  function automatic logic [15:0] get_reg(input logic [2:0] idx);
    case (idx)
      3'd0: return {4'h0, ar_w};
      3'd1: return {4'h0, pc_w};
      3'd2: return dr_w;
      3'd3: return ac_w;
      3'd4: return ir_w;
      3'd5: return tr_w;
      3'd6: return {8'h00, outr_w};
      default: return {8'h00, inpr_w};
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_sel = '0; ld = '0; inr = '0; clr = '0;
    mem_rd = 1'b0; mem_wr = 1'b0; inp_ld = 1'b0; ac_ld_inp = 1'b0;
  endtask

  task automatic all_zero(input string req);
    check(req, bus_w, 16'h0);
    for (int k = 0; k < 8; k++) check(req, get_reg(3'(k)), 16'h0);
  endtask

  initial begin
    vec_t v;
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    all_zero("R9 reset");

    // vector table
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      bus_sel = v.sel; ld = v.ld; inr = v.inr; clr = v.clr;
      inp_ld = v.inp_ld; ac_ld_inp = v.ac_inp; mem_rd = v.rd; mem_wr = v.wr;
      in_byte = v.din;
      #5;
      check($sformatf("R1 bus vec%0d", i), bus_w, v.exp_bus);
      @(posedge clk); #5;
      check($sformatf("R2-path vec%0d", i), get_reg(v.chk), v.exp_val);
      @(negedge clk);
      idle();
    end

    // R3 long increment of the temporary register past 12 bits
    clr = 7'h20;
    @(negedge clk);
    idle(); inr = 7'h20;
    repeat (16'h1005) @(negedge clk);
    idle();
    check("R3 tr count", tr_w, 16'h1005);
    bus_sel = 3'd6;
    #5 check("R1 tr on bus", bus_w, 16'h1005);
    // R2 truncation into narrow registers
    ld = 7'h43;
    @(negedge clk);
    idle();
    check("R2 ar trunc", {4'h0, ar_w}, 16'h0005);
    check("R2 pc trunc", {4'h0, pc_w}, 16'h0005);
    check("R7 outr trunc", {8'h00, outr_w}, 16'h0005);
    check("R7 tr intact", tr_w, 16'h1005);
    bus_sel = 3'd1;
    #5 check("R1 zero extend", bus_w, 16'h0005);
    @(negedge clk);
    idle();

    // R9 asynchronous assertion mid-run
    #3 rst_n = 1'b0;
    #2 all_zero("R9 async clear");
    @(negedge clk);
    rst_n = 1'b1;
    // strobe during release window is ignored
    inr = 7'h02;
    @(negedge clk);
    idle();
    check("R9 release hold", {4'h0, pc_w}, 16'h0000);
    @(negedge clk);
    inr = 7'h02;
    @(negedge clk);
    idle();
    check("R9 active after release", {4'h0, pc_w}, 16'h0001);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule